// File: doc/BRIEF.md
# Low-Voltage Reset Qualifier

This block turns the digital output of an external supply comparator into a qualified internal reset. It runs on the 32768 Hz clock. A low-supply indication counts only after it has been held without a break for a minimum dwell time, which is just over one millisecond. Shorter dips are discarded. The qualified condition is combined with a synchronized external reset request to form the chip reset.

When a reset source becomes active while the device is halted, the block emits a one-cycle wake pulse together with the rising chip reset. It also sets a sticky power-down flag, which software later clears through a dedicated clear input.

A two-bit configuration code selects one of three behaviours:
- both the reset and the detector are on;
- only the detector is on, so its enable output is high but supply dips never reset the chip;
- both are off.

Top module: `lvr_qualifier`

## Requirements
- R1: While `rst` is sampled high, and after it, every output (`chip_reset`, `wake_pulse`, `pd_flag`, `detect_en`) is 0 until an input stimulus changes it.
- R2: With `mode_sel` = 2'b11, `chip_reset` rises at the rising edge that samples `lv_flag` high for the 33rd consecutive time. A run of 32 or fewer high samples has no effect, and any low sample restarts the count.
- R3: Once qualified, `chip_reset` stays high while `lv_flag` stays high. It falls at the first rising edge that samples `lv_flag` low, unless the external reset is active.
- R4: `ext_reset` (active high) passes through a two-flop synchronizer. `chip_reset` goes high at the third rising edge after `ext_reset` is first sampled high, and low at the third edge after it is sampled low. This holds in every mode.
- R5: `pd_flag` is set to 1 at any edge where a reset source (qualified low voltage or synchronized external reset) is active while `halted` is 1. It then holds. `pd_clear` clears it, but a simultaneous set wins.
- R6: `wake_pulse` is high for exactly the one cycle in which `chip_reset` rises, and only if `halted` was 1 at that edge.
- R7: Mode codes: 2'b11 enables both the reset and the detector, 2'b01 enables only the detector, and 2'b00 and 2'b10 disable both. `detect_en` shows the detector enable one edge after `mode_sel` changes.
- R8: With any `mode_sel` other than 2'b11, `lv_flag` has no effect on `chip_reset`, `wake_pulse` or `pd_flag`, whatever the length of the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz clock |
| rst | input | 1 | Synchronous active-high power-on reset of the block |
| lv_flag | input | 1 | Low-supply indication from the comparator, high = supply low |
| ext_reset | input | 1 | External reset request, active high, asynchronous |
| halted | input | 1 | Device is in its halt state |
| mode_sel | input | 2 | Reset/detector enable code (see R7) |
| pd_clear | input | 1 | Clears the power-down flag (software write) |
| chip_reset | output | 1 | Combined chip reset, registered |
| wake_pulse | output | 1 | One-cycle wake-up request from halt |
| pd_flag | output | 1 | Sticky power-down flag |
| detect_en | output | 1 | Enable for the voltage detector |

## Verification
The hardest case to reach is the exact qualification boundary: a dip that ends at 32 samples against one that reaches 33. The case is harder still when the 33rd sample coincides with the halted state, a pending flag clear, or an external reset that is already rising through the synchronizer. Directed runs of exactly 32 and 33 samples cover the boundary itself. The random phase draws most run lengths from a narrow window around 33, while toggling `halted`, `pd_clear` and `ext_reset`, so that the overlaps occur many times.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

  typedef enum logic [1:0] {
    LVM_OFF      = 2'b00,
    LVM_DET_ONLY = 2'b01,
    LVM_OFF_ALT  = 2'b10,
    LVM_FULL     = 2'b11
  } lvr_mode_e;

  // Detector runs in both codes whose low bit is set.
  function automatic logic detector_on(input logic [1:0] code);
    return code[0];
  endfunction

  // Reset path runs only in the full mode.
  function automatic logic reset_on(input logic [1:0] code);
    return code == LVM_FULL;
  endfunction

endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  initial begin
    assert_stages_min_R4: assert (STAGES >= 2)
      else $error("synchronizer needs at least two stages");
  end

endmodule

// File: rtl/lvr_dwell.sv
module lvr_dwell #(
  parameter int QUAL_CYCLES = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic enable,
  output logic hit
);

  localparam int CW = $clog2(QUAL_CYCLES);
  localparam logic [CW-1:0] CAP = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_len;
  logic          active;

  assign active = level & enable;
  // Qualified on the sample that completes the run.
  assign hit = active & (run_len == CAP);

  always_ff @(posedge clk) begin
    if (rst || !active)      run_len <= '0;
    else if (run_len != CAP) run_len <= run_len + 1'b1;
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    run_len <= CAP);

  assert_clear_on_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !active |=> run_len == '0);

endmodule

// File: rtl/lvr_qualifier.sv
module lvr_qualifier
  import lvr_pkg::*;
#(
  parameter int QUAL_CYCLES = 33,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lv_flag,
  input  logic       ext_reset,
  input  logic       halted,
  input  logic [1:0] mode_sel,
  input  logic       pd_clear,
  output logic       chip_reset,
  output logic       wake_pulse,
  output logic       pd_flag,
  output logic       detect_en
);

  logic ext_sync;
  logic lv_hit;
  logic src_any;

  lvr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_reset),
    .q   (ext_sync)
  );

  lvr_dwell #(.QUAL_CYCLES(QUAL_CYCLES)) u_dwell (
    .clk    (clk),
    .rst    (rst),
    .level  (lv_flag),
    .enable (reset_on(mode_sel)),
    .hit    (lv_hit)
  );

  assign src_any = lv_hit | ext_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_reset <= 1'b0;
      wake_pulse <= 1'b0;
      pd_flag    <= 1'b0;
      detect_en  <= 1'b0;
    end else begin
      chip_reset <= src_any;
      wake_pulse <= src_any & ~chip_reset & halted;
      if (src_any && halted) pd_flag <= 1'b1;
      else if (pd_clear)     pd_flag <= 1'b0;
      detect_en  <= detector_on(mode_sel);
    end
  end

  assert_pd_set_halted_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag) |-> $past(halted));

  assert_wake_with_rise_R6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (chip_reset && !$past(chip_reset)));

  assert_lv_gated_by_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (chip_reset && !$past(ext_sync)) |-> $past(mode_sel) == LVM_FULL);

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (!ext_sync && !lv_flag) |=> !chip_reset);

endmodule

// File: tb/tb_lvr_qualifier.sv
module tb_lvr_qualifier;

  localparam int CLK_PERIOD = 20;
  localparam int QUAL = 33;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst, lv_flag, ext_reset, halted, pd_clear;
  logic [1:0] mode_sel;
  logic chip_reset, wake_pulse, pd_flag, detect_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  string tag = "R1";

  // Reference state derived from the requirements
  int   m_run;
  logic m_s1, m_s2, m_cr, m_wk, m_pd, m_de;

  lvr_qualifier #(.QUAL_CYCLES(QUAL), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .lv_flag(lv_flag), .ext_reset(ext_reset),
    .halted(halted), .mode_sel(mode_sel), .pd_clear(pd_clear),
    .chip_reset(chip_reset), .wake_pulse(wake_pulse),
    .pd_flag(pd_flag), .detect_en(detect_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit lv_qualifies(int run, logic lv, logic [1:0] m);
    return lv && (m == 2'b11) && (run >= QUAL - 1);
  endfunction

  function automatic int next_run(int run, logic lv, logic [1:0] m);
    if (!(lv && m == 2'b11)) return 0;
    return (run >= QUAL - 1) ? QUAL - 1 : run + 1;
  endfunction

  task automatic check(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", t, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit src;
    cycles++;
    if (rst) begin
      m_run = 0; m_s1 = 0; m_s2 = 0; m_cr = 0; m_wk = 0; m_pd = 0; m_de = 0;
    end else begin
      src  = lv_qualifies(m_run, lv_flag, mode_sel) || m_s2;
      m_wk = src && !m_cr && halted;
      m_cr = src;
      if (src && halted) m_pd = 1'b1;
      else if (pd_clear) m_pd = 1'b0;
      m_de = mode_sel[0];
      m_run = next_run(m_run, lv_flag, mode_sel);
      m_s2 = m_s1;
      m_s1 = ext_reset;
    end
    #(CLK_PERIOD/4);
    if (!finished) begin
      check(tag, "chip_reset", chip_reset, m_cr);
      check(tag, "wake_pulse", wake_pulse, m_wk);
      check(tag, "pd_flag",    pd_flag,    m_pd);
      check(tag, "detect_en",  detect_en,  m_de);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1; lv_flag = 0; ext_reset = 0; halted = 0; pd_clear = 0; mode_sel = 2'b11;
    tick(3);
    check("R1", "chip_reset after reset", chip_reset, 1'b0);
    check("R1", "pd_flag after reset", pd_flag, 1'b0);
    rst = 0;
    tick(2);

    // R2: 32-sample dip is ignored, 33 qualifies
    tag = "R2";
    lv_flag = 1; tick(32);
    check("R2", "no reset after 32 samples", chip_reset, 1'b0);
    lv_flag = 0; tick(1);
    lv_flag = 1; tick(33);
    check("R2", "reset after 33 samples", chip_reset, 1'b1);
    // R3: hold while flag stays, release at first low sample
    tag = "R3";
    tick(20);
    check("R3", "held while low supply persists", chip_reset, 1'b1);
    lv_flag = 0; tick(1);
    check("R3", "released one edge after flag drop", chip_reset, 1'b0);
    tick(3);

    // R4: external reset in a disabled mode
    tag = "R4";
    mode_sel = 2'b00;
    ext_reset = 1; tick(2);
    check("R4", "not yet through synchronizer", chip_reset, 1'b0);
    tick(1);
    check("R4", "asserted at third edge", chip_reset, 1'b1);
    ext_reset = 0; tick(3);
    check("R4", "released at third edge", chip_reset, 1'b0);

    // R5/R6: qualified reset while halted
    tag = "R5 R6";
    mode_sel = 2'b11; halted = 1; tick(2);
    lv_flag = 1; tick(33);
    check("R6", "wake pulse with rising reset", wake_pulse, 1'b1);
    check("R5", "pd flag set", pd_flag, 1'b1);
    tick(1);
    check("R6", "wake pulse lasts one cycle", wake_pulse, 1'b0);
    pd_clear = 1; tick(1);
    check("R5", "set wins over clear", pd_flag, 1'b1);
    lv_flag = 0; tick(1); pd_clear = 0; tick(1);
    check("R5", "cleared after source gone", pd_flag, 1'b0);
    halted = 0; lv_flag = 1; tick(34);
    check("R6", "no wake when not halted", wake_pulse, 1'b0);
    check("R5", "pd flag stays clear when not halted", pd_flag, 1'b0);
    lv_flag = 0; tick(2);

    // R7: mode codes and detector enable
    tag = "R7";
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m); tick(1);
      check("R7", "detect_en follows code", detect_en, logic'(m[0]));
    end

    // R8: long low-supply runs in non-full modes
    tag = "R8";
    halted = 1;
    for (int m = 0; m < 3; m++) begin
      mode_sel = 2'(m); lv_flag = 1; tick(60);
      check("R8", "lv ignored outside full mode", chip_reset, 1'b0);
      check("R8", "no pd set outside full mode", pd_flag, 1'b0);
      lv_flag = 0; tick(1);
    end
    halted = 0;

    // Random phase across R2 R3 R4 R5 R6 R7 R8
    tag = "random R2-R8 mix";
    void'($urandom(32'd1234));
    for (int i = 0; i < 1500; i++) begin
      int len;
      len = ($urandom % 4 == 0) ? 1 + $urandom % 45 : 30 + $urandom % 6;
      mode_sel  = ($urandom % 5 == 0) ? 2'($urandom) : 2'b11;
      halted    = ($urandom % 2 == 0);
      pd_clear  = ($urandom % 3 == 0);
      ext_reset = ($urandom % 12 == 0);
      lv_flag = 1; tick(len);
      lv_flag = 0; pd_clear = ($urandom % 2 == 0); tick(1 + $urandom % 3);
    end
    ext_reset = 0; tick(5);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule